// File: doc/BRIEF.md
# Clock-Edge Search Delay Calibrator

This block removes the insertion delay of a buffered copy of a forwarded, center-aligned source-synchronous clock. The incoming clock is captured as data by its own buffered copy, after an input delay line. The block moves that delay line upward one tap at a time, starting at tap 0, until the captured value goes from low to high between two consecutive samples. At that point the buffered clock samples the raw clock right at its rising edge. The buffered clock is then one period late but in phase, so it sits at the center of the data eye.

The block works in two clock domains. In the buffered-clock domain it registers the captured bit and keeps the previous sample. It sets a sticky lock flag on a rising transition, and it sets a flag showing that the buffered clock runs. In the system-clock domain it synchronizes both flags and runs the search. It issues single-cycle enable pulses with the direction fixed to increment, and waits a settle period after each step. It reports done, fail and the reached tap. The delay primitive, the I/O buffers and the data capture path are outside the block.

Top module: `edge_cal_top`

## Requirements
- R1: While `rst_ni` is low, and on its release, `done_o`, `fail_o` and `dly_en_o` are 0 and `tap_o` is 0.
- R2: Each step is a `dly_en_o` pulse of exactly one system-clock cycle with `dly_inc_o` = 1. `tap_o` rises by exactly 1 in the cycle the pulse is high, and it never decreases.
- R3: No step is issued until the buffered clock has run after reset. This "running" flag is set on the first buffered-clock edge and crosses to the system clock through two flops. If it is not seen within RUN_TMO (default 1024) system-clock cycles, `fail_o` rises with zero steps issued and `tap_o` = 0.
- R4: Reset drives the current-sample and previous-sample registers to 1. A sample input held at 1 from reset onward therefore never yields lock: the search ends in fail at tap 31.
- R5: Lock is a current sample of 1 with a previous sample of 0. The lock flag stays set until reset, even if the sample returns to 0. It reaches the system-clock domain through three flops.
- R6: Consecutive steps are at least SETTLE_CYC (default 16) system-clock cycles apart, counted from the cycle after one pulse to the next pulse. Lock is tested only after the settle period.
- R7: When lock is seen, `done_o` rises and stepping stops. `tap_o` holds the tap at which the sample first went high. Later sample activity has no effect on `tap_o`, `dly_en_o` or `done_o`.
- R8: If the 5-bit tap reaches 31 and the settle period ends without lock, `fail_o` rises, `done_o` stays 0, `tap_o` = 31 and no further step is issued.
- R9: `done_o` and `fail_o` are never high together, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | System clock; the search runs here |
| bclk_i | input | 1 | Buffered (delayed) copy of the forwarded clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| samp_i | input | 1 | Raw forwarded clock as captured by `bclk_i` |
| dly_en_o | output | 1 | One-cycle delay-line step enable |
| dly_inc_o | output | 1 | Step direction, held at increment |
| tap_o | output | 5 | Current tap count; final tap after done or fail |
| done_o | output | 1 | Lock found, search finished |
| fail_o | output | 1 | No lock by the last tap, or buffered clock absent |

## Verification
The bench models the delay line. It counts the enable pulses and drives the sample high once its tap count reaches a target tap, drawn at random in 1 to 31 plus the corner taps 1 and 31. A correct run must finish done at exactly that tap, which shows that the steps, the settle wait and the lock crossing line up. In a second pattern the sample is high for only a moment at the target tap, which shows whether the lock flag is sticky. A sample held at 1 from reset shows that reset gives no false edge. A sample that is never high shows the fail at the top tap. A buffered clock that never starts shows the timeout path and that no step is issued without a running clock. After each done, random sample toggling shows that the finished state is frozen.

// File: rtl/edge_cal_pkg.sv
package edge_cal_pkg;
  typedef enum logic [1:0] {
    CS_WAIT_RUN,
    CS_SETTLE,
    CS_CHECK,
    CS_END
  } cal_st_e;
endpackage

// File: rtl/edge_cal_sampler.sv
// Buffered-clock domain: sample history, sticky lock, running flag.
module edge_cal_sampler (
  input  logic bclk_i,
  input  logic rst_ni,
  input  logic samp_i,
  output logic lock_o,
  output logic run_o
);
  logic cur_q, prev_q, lock_q, run_q;

  // Both history bits reset high: no edge can be seen at reset release.
  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
      lock_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cur_q  <= samp_i;
      prev_q <= cur_q;
      run_q  <= 1'b1;
      if (cur_q && !prev_q) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign run_o  = run_q;
endmodule

// File: rtl/edge_cal_sync.sv
module edge_cal_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_cal_ctrl.sv
// System-clock domain search: wait for running clock, settle, test, step.
module edge_cal_ctrl
  import edge_cal_pkg::*;
#(
  parameter int unsigned TAP_W      = 5,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned RUN_TMO    = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_s_i,
  input  logic             lock_s_i,
  output logic             dly_en_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             done_o,
  output logic             fail_o
);
  localparam int unsigned CNT_MAX = (RUN_TMO > SETTLE_CYC) ? RUN_TMO : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [TAP_W-1:0] TAP_TOP = {TAP_W{1'b1}};
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(RUN_TMO - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);

  cal_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W-1:0] tap_q;
  logic             en_q, done_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CS_WAIT_RUN;
      cnt_q  <= '0;
      tap_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      en_q <= 1'b0;
      unique case (st_q)
        CS_WAIT_RUN: begin
          if (run_s_i) begin
            st_q  <= CS_SETTLE;
            cnt_q <= '0;
          end else if (cnt_q == TMO_LAST) begin
            fail_q <= 1'b1;
            st_q   <= CS_END;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        CS_SETTLE: begin
          if (cnt_q == SET_LAST) st_q <= CS_CHECK;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        CS_CHECK: begin
          if (lock_s_i) begin
            done_q <= 1'b1;
            st_q   <= CS_END;
          end else if (tap_q == TAP_TOP) begin
            fail_q <= 1'b1;
            st_q   <= CS_END;
          end else begin
            en_q  <= 1'b1;
            tap_q <= tap_q + 1'b1;
            cnt_q <= '0;
            st_q  <= CS_SETTLE;
          end
        end
        CS_END: ;
        default: st_q <= CS_END;
      endcase
    end
  end

  assign dly_en_o = en_q;
  assign tap_o    = tap_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/edge_cal_top.sv
module edge_cal_top #(
  parameter int unsigned TAP_W      = 5,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned RUN_TMO    = 1024,
  parameter int unsigned LOCK_SYNC  = 3,
  parameter int unsigned RUN_SYNC   = 2
) (
  input  logic             sclk_i,
  input  logic             bclk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  output logic             dly_en_o,
  output logic             dly_inc_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             done_o,
  output logic             fail_o
);
  logic lock_b, run_b, lock_s, run_s;

  edge_cal_sampler u_smp (
    .bclk_i (bclk_i),
    .rst_ni (rst_ni),
    .samp_i (samp_i),
    .lock_o (lock_b),
    .run_o  (run_b)
  );

  edge_cal_sync #(.STAGES(LOCK_SYNC)) u_lock_sync (
    .clk_i  (sclk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_b),
    .q_o    (lock_s)
  );

  edge_cal_sync #(.STAGES(RUN_SYNC)) u_run_sync (
    .clk_i  (sclk_i),
    .rst_ni (rst_ni),
    .d_i    (run_b),
    .q_o    (run_s)
  );

  edge_cal_ctrl #(
    .TAP_W      (TAP_W),
    .SETTLE_CYC (SETTLE_CYC),
    .RUN_TMO    (RUN_TMO)
  ) u_ctrl (
    .clk_i    (sclk_i),
    .rst_ni   (rst_ni),
    .run_s_i  (run_s),
    .lock_s_i (lock_s),
    .dly_en_o (dly_en_o),
    .tap_o    (tap_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );

  assign dly_inc_o = 1'b1;
endmodule

// File: rtl/edge_cal_chk.sv
module edge_cal_chk #(
  parameter int unsigned TAP_W      = 5,
  parameter int unsigned SETTLE_CYC = 16
) (
  input logic             sclk_i,
  input logic             rst_ni,
  input logic             dly_en_o,
  input logic             dly_inc_o,
  input logic [TAP_W-1:0] tap_o,
  input logic             done_o,
  input logic             fail_o
);
  logic [15:0] gap_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= '0;
    else if (dly_en_o)  gap_q <= '0;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
  end

  // R2
  step_single_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    dly_en_o |=> !dly_en_o);
  // R2
  step_dir_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    dly_en_o |-> dly_inc_o);
  // R2
  tap_step_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $rose(dly_en_o) |-> tap_o == $past(tap_o) + 1'b1);
  // R2
  tap_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !dly_en_o |-> $stable(tap_o));
  // R6
  settle_gap_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    dly_en_o |-> gap_q >= 16'(SETTLE_CYC));
  // R9
  excl_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  // R9
  done_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R9
  fail_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);
  // R7
  end_quiet_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> !dly_en_o);
  // R8
  fail_tap_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (tap_o == '0 || tap_o == {TAP_W{1'b1}}));
endmodule

bind edge_cal_top edge_cal_chk #(
  .TAP_W      (TAP_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .sclk_i    (sclk_i),
  .rst_ni    (rst_ni),
  .dly_en_o  (dly_en_o),
  .dly_inc_o (dly_inc_o),
  .tap_o     (tap_o),
  .done_o    (done_o),
  .fail_o    (fail_o)
);

// File: tb/edge_cal_top_tb_top.sv
`timescale 1ns/1ps
module edge_cal_top_tb_top;
  localparam int SETTLE = 16;
  localparam int TMO    = 1024;

  logic       sclk = 1'b0, bclk = 1'b0, rst_n = 1'b0, samp = 1'b0;
  logic       bclk_on = 1'b0;
  logic       en, inc, done, fail;
  logic [4:0] tap;

  int n_tests = 0, n_fail = 0;
  int tap_m = 0, cyc = 0, last_en = -1000, min_gap = 100000;
  int mode = 0, tgt = 0, hi_left = 0;   // mode 0 level, 1 pulse, 2 const high, 3 never high

  always #2.5 sclk = ~sclk;
  always #3.5 if (bclk_on) bclk = ~bclk; else bclk = 1'b0;

  edge_cal_top dut_i (
    .sclk_i(sclk), .bclk_i(bclk), .rst_ni(rst_n), .samp_i(samp),
    .dly_en_o(en), .dly_inc_o(inc), .tap_o(tap), .done_o(done), .fail_o(fail)
  );

  // delay-line model and sample generator
  always @(negedge sclk) begin
    cyc++;
    if (rst_n && en) begin
      tap_m++;
      if (cyc - last_en < min_gap) min_gap = cyc - last_en;
      last_en = cyc;
      if (mode == 1 && tap_m == tgt) hi_left = 4;
    end
    case (mode)
      0: samp = (tap_m >= tgt);
      1: begin samp = (hi_left > 0); if (hi_left > 0) hi_left--; end
      2: samp = 1'b1;
      default: samp = 1'b0;
    endcase
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tap(input int m, input int t, input bit clk_ok);
    if (!clk_ok) return 0;
    if (m == 2 || m == 3) return 31;
    return t;
  endfunction

  function automatic int exp_done(input int m, input bit clk_ok);
    return (clk_ok && (m == 0 || m == 1)) ? 1 : 0;
  endfunction

  task automatic run_case(input int m, input int t, input bit clk_ok, input string tag);
    int waited = 0;
    mode = m; tgt = t; hi_left = 0;
    rst_n = 1'b0; bclk_on = 1'b0;
    repeat (3) @(negedge sclk);
    tap_m = 0; min_gap = 100000; last_en = cyc;
    // R1 reset state
    check("R1 done", done, 0); check("R1 fail", fail, 0);
    check("R1 tap", tap, 0);   check("R1 en", en, 0);
    bclk_on = clk_ok;
    @(negedge sclk); rst_n = 1'b1;
    while (!done && !fail && waited < 3000) begin
      @(negedge sclk); waited++;
    end
    if (waited >= 3000) check({tag, " timeout"}, 1, 0);
    check({tag, " done"}, done, exp_done(m, clk_ok));
    check({tag, " fail"}, fail, 1 - exp_done(m, clk_ok));
    check({tag, " tap"}, tap, exp_tap(m, t, clk_ok));
    check({tag, " steps"}, tap_m, exp_tap(m, t, clk_ok));
    if (!clk_ok) check("R3 timeout window", (waited >= TMO - 2 && waited <= TMO + 4) ? 1 : 0, 1);
    if (tap_m > 1) check("R6 gap", (min_gap >= SETTLE) ? 1 : 0, 1);
    check({tag, " inc"}, inc, 1);
    if (done) begin
      // R7: later sample activity is ignored
      mode = 4;
      for (int i = 0; i < 60; i++) begin
        samp = 1'($urandom);
        @(negedge sclk);
      end
      check("R7 tap frozen", tap, t);
      check("R7 no steps", tap_m, t);
      check("R7 done held", done, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd77));
    run_case(0, 1, 1'b1, "R7 lock tap1");
    run_case(0, 31, 1'b1, "R7 lock tap31");
    run_case(1, 9, 1'b1, "R5 sticky pulse");
    run_case(2, 0, 1'b1, "R4 const high");
    run_case(3, 0, 1'b1, "R8 never high");
    run_case(0, 5, 1'b0, "R3 no bclk");
    for (int k = 0; k < 8; k++) begin
      int t;
      t = 1 + int'($urandom_range(30));
      run_case(int'($urandom_range(1)), t, 1'b1, "R2 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule